// File: doc/BRIEF.md
# Byte-Granular Register Pair Shifter

This block carries out the shift instructions of a word machine whose registers are sign-magnitude. Each register is a sign bit plus five 6-bit magnitude bytes. The bytes are numbered 1 (most significant) through 5 (least significant). A caller presents the accumulator, the extension register, the overflow flag, a shift count and a 3-bit operation code, then pulses `start_i` for one cycle. Two cycles later the block returns both magnitudes, both signs and the overflow flag, with `done_o` high for that one cycle.

Six operations are supported:

| Code | Operation |
|------|-----------|
| 0 | Shift the accumulator alone left by whole bytes |
| 1 | Shift the accumulator alone right by whole bytes |
| 2 | Shift the accumulator and extension, joined as one ten-byte value, left |
| 3 | Shift the joined ten-byte value right |
| 4 | Rotate the joined ten-byte value left |
| 5 | Rotate the joined ten-byte value right |

In the joined value the accumulator is the upper half. Codes 6 and 7 are reserved. Signs and the overflow flag always pass through untouched.

The block accepts a new request every cycle, and requests flow through in order. Between results the outputs keep their last values.

Top module: `byte_pair_shifter`

## Requirements
- R1: Code 0 moves the accumulator magnitude left by the count in bytes, toward byte 1 (bits [29:24]). Zero bytes enter at byte 5. The extension magnitude is returned unchanged.
- R2: Code 1 moves the accumulator magnitude right by the count in bytes, toward byte 5 (bits [5:0]). Zero bytes enter at byte 1. The extension magnitude is returned unchanged.
- R3: Code 2 shifts the ten-byte value {accumulator, extension} left by the count in bytes, with zero fill. Bytes cross from the extension into the accumulator.
- R4: Code 3 shifts the ten-byte value right by the count in bytes, with zero fill. Bytes cross from the accumulator into the extension.
- R5: Code 4 rotates the ten-byte value left. Bytes leaving byte 1 of the accumulator re-enter at byte 5 of the extension.
- R6: Code 5 rotates the ten-byte value right. Bytes leaving byte 5 of the extension re-enter at byte 1 of the accumulator.
- R7: Both returned sign bits equal the signs presented with the request, for every code.
- R8: The returned overflow flag equals the flag presented with the request, for every code.
- R9: Linear shifts produce an all-zero magnitude for the affected bytes when the count reaches the affected width. That width is 5 for codes 0 and 1, and 10 for codes 2 and 3.
- R10: For codes 4 and 5, the count is taken modulo 10.
- R11: A count of zero returns both magnitudes unchanged.
- R12: Codes 6 and 7 return both magnitudes unchanged and raise `unsupported_o` together with `done_o`. For codes 0 to 5, `unsupported_o` stays low.
- R13: `done_o` and the result appear exactly two rising edges after the edge that samples `start_i`, with one result per request and back-to-back requests allowed. While `done_o` is low, all result outputs hold their previous values.
- R14: While `rst_n` is low, `done_o`, `unsupported_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, one cycle per request |
| op_i | input | 3 | Operation code, 0 to 7 |
| count_i | input | 12 | Non-negative shift count in bytes |
| acc_sign_i | input | 1 | Accumulator sign |
| acc_mag_i | input | 30 | Accumulator magnitude, byte 1 in [29:24] |
| ext_sign_i | input | 1 | Extension sign |
| ext_mag_i | input | 30 | Extension magnitude, byte 1 in [29:24] |
| ovf_i | input | 1 | Overflow flag in |
| done_o | output | 1 | Result strobe |
| unsupported_o | output | 1 | Reserved code was requested |
| acc_sign_o | output | 1 | Returned accumulator sign |
| acc_mag_o | output | 30 | Returned accumulator magnitude |
| ext_sign_o | output | 1 | Returned extension sign |
| ext_mag_o | output | 30 | Returned extension magnitude |
| ovf_o | output | 1 | Returned overflow flag |

## Verification
Every result, strobe, sign and flag is due two rising edges after the edge that captured its request. Nothing is due at an earlier or later edge. At each rising edge where `start_i` is high, the bench computes the expected result from a byte-array model and queues it, tagged with the edge number two edges ahead. At every falling edge it compares the outputs against the head of the queue if that edge number has arrived; otherwise it requires `done_o` low and the outputs unchanged. Because of this, back-to-back requests and idle gaps are judged under the same timing rule.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [2:0] {
        SH_ACC_L  = 3'd0,
        SH_ACC_R  = 3'd1,
        SH_PAIR_L = 3'd2,
        SH_PAIR_R = 3'd3,
        SH_ROT_L  = 3'd4,
        SH_ROT_R  = 3'd5,
        SH_RSV_6  = 3'd6,
        SH_RSV_7  = 3'd7
    } shift_op_e;

endpackage

// File: rtl/bps_count_norm.sv
module bps_count_norm
    import bps_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NBYTES = 5,
    parameter int AMT_W  = 4
) (
    input  logic [2:0]       op_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [AMT_W-1:0] amt_o,
    output logic             unsup_o
);

    localparam int TOTAL = 2 * NBYTES;
    localparam logic [CNT_W-1:0] LIM_ACC  = CNT_W'(NBYTES);
    localparam logic [CNT_W-1:0] LIM_PAIR = CNT_W'(TOTAL);

    shift_op_e op;
    logic [CNT_W-1:0] wrapped;

    assign op      = shift_op_e'(op_i);
    assign wrapped = count_i % LIM_PAIR;

    always_comb begin
        amt_o   = '0;
        unsup_o = 1'b0;
        unique case (op)
            SH_ACC_L, SH_ACC_R: begin
                amt_o = (count_i >= LIM_ACC) ? AMT_W'(NBYTES) : AMT_W'(count_i);
            end
            SH_PAIR_L, SH_PAIR_R: begin
                amt_o = (count_i >= LIM_PAIR) ? AMT_W'(TOTAL) : AMT_W'(count_i);
            end
            SH_ROT_L, SH_ROT_R: begin
                amt_o = AMT_W'(wrapped);
            end
            default: begin
                unsup_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bps_byte_barrel.sv
module bps_byte_barrel #(
    parameter int BYTE_W = 6,
    parameter int NB     = 10,
    parameter int AMT_W  = 4
) (
    input  logic [NB*BYTE_W-1:0] data_i,
    input  logic [AMT_W-1:0]     amt_i,
    input  logic                 left_i,
    input  logic                 rotate_i,
    output logic [NB*BYTE_W-1:0] data_o
);

    localparam int TW = NB * BYTE_W;

    logic [TW-1:0] stage [AMT_W+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int LB = (1 << s) * BYTE_W;
        localparam int RB = ((1 << s) % NB) * BYTE_W;

        logic [TW-1:0] lin_l;
        logic [TW-1:0] lin_r;
        logic [TW-1:0] rot_l;
        logic [TW-1:0] rot_r;
        logic [TW-1:0] pick;

        if (LB >= TW) begin : g_flush
            assign lin_l = '0;
            assign lin_r = '0;
        end else begin : g_lin
            assign lin_l = {stage[s][TW-LB-1:0], {LB{1'b0}}};
            assign lin_r = {{LB{1'b0}}, stage[s][TW-1:LB]};
        end

        if (RB == 0) begin : g_rot_id
            assign rot_l = stage[s];
            assign rot_r = stage[s];
        end else begin : g_rot
            assign rot_l = {stage[s][TW-RB-1:0], stage[s][TW-1 -: RB]};
            assign rot_r = {stage[s][RB-1:0], stage[s][TW-1:RB]};
        end

        always_comb begin
            if (rotate_i) begin
                pick = left_i ? rot_l : rot_r;
            end else begin
                pick = left_i ? lin_l : lin_r;
            end
        end

        assign stage[s+1] = amt_i[s] ? pick : stage[s];
    end

    assign data_o = stage[AMT_W];

endmodule

// File: rtl/byte_pair_shifter.sv
module byte_pair_shifter
    import bps_pkg::*;
#(
    parameter int BYTE_W = 6,
    parameter int NBYTES = 5,
    parameter int CNT_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [2:0]               op_i,
    input  logic [CNT_W-1:0]         count_i,
    input  logic                     acc_sign_i,
    input  logic [BYTE_W*NBYTES-1:0] acc_mag_i,
    input  logic                     ext_sign_i,
    input  logic [BYTE_W*NBYTES-1:0] ext_mag_i,
    input  logic                     ovf_i,
    output logic                     done_o,
    output logic                     unsupported_o,
    output logic                     acc_sign_o,
    output logic [BYTE_W*NBYTES-1:0] acc_mag_o,
    output logic                     ext_sign_o,
    output logic [BYTE_W*NBYTES-1:0] ext_mag_o,
    output logic                     ovf_o
);

    localparam int MAG_W = BYTE_W * NBYTES;
    localparam int TOTAL = 2 * NBYTES;
    localparam int AMT_W = $clog2(TOTAL + 1);

    typedef struct packed {
        // capture stage
        logic             cap_v;
        shift_op_e        cap_op;
        logic [AMT_W-1:0] cap_amt;
        logic             cap_unsup;
        logic             cap_as;
        logic             cap_xs;
        logic             cap_ov;
        logic [MAG_W-1:0] cap_am;
        logic [MAG_W-1:0] cap_xm;
        // result stage
        logic             res_v;
        logic             res_unsup;
        logic             res_as;
        logic             res_xs;
        logic             res_ov;
        logic [MAG_W-1:0] res_am;
        logic [MAG_W-1:0] res_xm;
    } state_t;

    state_t st_d, st_q;

    logic [AMT_W-1:0]   norm_amt;
    logic               norm_unsup;
    logic [2*MAG_W-1:0] pair_in;
    logic [2*MAG_W-1:0] pair_out;
    logic [MAG_W-1:0]   acc_out;
    logic               pair_left;
    logic               pair_rot;
    logic               acc_left;

    bps_count_norm #(
        .CNT_W (CNT_W),
        .NBYTES(NBYTES),
        .AMT_W (AMT_W)
    ) u_norm (
        .op_i   (op_i),
        .count_i(count_i),
        .amt_o  (norm_amt),
        .unsup_o(norm_unsup)
    );

    assign pair_in   = {st_q.cap_am, st_q.cap_xm};
    assign pair_left = (st_q.cap_op == SH_PAIR_L) || (st_q.cap_op == SH_ROT_L);
    assign pair_rot  = (st_q.cap_op == SH_ROT_L)  || (st_q.cap_op == SH_ROT_R);
    assign acc_left  = (st_q.cap_op == SH_ACC_L);

    bps_byte_barrel #(
        .BYTE_W(BYTE_W),
        .NB    (TOTAL),
        .AMT_W (AMT_W)
    ) u_pair (
        .data_i  (pair_in),
        .amt_i   (st_q.cap_amt),
        .left_i  (pair_left),
        .rotate_i(pair_rot),
        .data_o  (pair_out)
    );

    bps_byte_barrel #(
        .BYTE_W(BYTE_W),
        .NB    (NBYTES),
        .AMT_W (AMT_W)
    ) u_acc (
        .data_i  (st_q.cap_am),
        .amt_i   (st_q.cap_amt),
        .left_i  (acc_left),
        .rotate_i(1'b0),
        .data_o  (acc_out)
    );

    always_comb begin
        st_d = st_q;

        // capture stage
        st_d.cap_v = start_i;
        if (start_i) begin
            st_d.cap_op    = shift_op_e'(op_i);
            st_d.cap_amt   = norm_amt;
            st_d.cap_unsup = norm_unsup;
            st_d.cap_as    = acc_sign_i;
            st_d.cap_xs    = ext_sign_i;
            st_d.cap_ov    = ovf_i;
            st_d.cap_am    = acc_mag_i;
            st_d.cap_xm    = ext_mag_i;
        end

        // result stage
        st_d.res_v     = st_q.cap_v;
        st_d.res_unsup = st_q.cap_v & st_q.cap_unsup;
        if (st_q.cap_v) begin
            st_d.res_as = st_q.cap_as;
            st_d.res_xs = st_q.cap_xs;
            st_d.res_ov = st_q.cap_ov;
            unique case (st_q.cap_op)
                SH_ACC_L, SH_ACC_R: begin
                    st_d.res_am = acc_out;
                    st_d.res_xm = st_q.cap_xm;
                end
                SH_PAIR_L, SH_PAIR_R, SH_ROT_L, SH_ROT_R: begin
                    st_d.res_am = pair_out[2*MAG_W-1:MAG_W];
                    st_d.res_xm = pair_out[MAG_W-1:0];
                end
                default: begin
                    st_d.res_am = st_q.cap_am;
                    st_d.res_xm = st_q.cap_xm;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o        = st_q.res_v;
    assign unsupported_o = st_q.res_unsup;
    assign acc_sign_o    = st_q.res_as;
    assign acc_mag_o     = st_q.res_am;
    assign ext_sign_o    = st_q.res_xs;
    assign ext_mag_o     = st_q.res_xm;
    assign ovf_o         = st_q.res_ov;

endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
    parameter int MAG_W = 30,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [2:0]       op_i,
    input logic [CNT_W-1:0] count_i,
    input logic             acc_sign_i,
    input logic [MAG_W-1:0] acc_mag_i,
    input logic             ext_sign_i,
    input logic [MAG_W-1:0] ext_mag_i,
    input logic             ovf_i,
    input logic             done_o,
    input logic             unsupported_o,
    input logic             acc_sign_o,
    input logic [MAG_W-1:0] acc_mag_o,
    input logic             ext_sign_o,
    input logic [MAG_W-1:0] ext_mag_o,
    input logic             ovf_o
);

    AST_DONE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ##2 done_o); // R13

    AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2)); // R13

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(acc_mag_o) && $stable(ext_mag_o) && $stable(acc_sign_o)
                     && $stable(ext_sign_o) && $stable(ovf_o))); // R13

    AST_ACC_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (acc_sign_o == $past(acc_sign_i, 2))); // R7

    AST_EXT_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ext_sign_o == $past(ext_sign_i, 2))); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ovf_o == $past(ovf_i, 2))); // R8

    AST_ACC_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(op_i, 2) <= 3'd1)) |-> (ext_mag_o == $past(ext_mag_i, 2))); // R1

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(count_i, 2) == '0)) |->
            ((acc_mag_o == $past(acc_mag_i, 2)) && (ext_mag_o == $past(ext_mag_i, 2)))); // R11

    AST_UNSUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (unsupported_o == ($past(op_i, 2) >= 3'd6))); // R12

    AST_UNSUP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> ((acc_mag_o == $past(acc_mag_i, 2)) && (ext_mag_o == $past(ext_mag_i, 2)))); // R12

    AST_UNSUP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> done_o); // R12

endmodule

bind byte_pair_shifter bps_checker #(
    .MAG_W(MAG_W),
    .CNT_W(CNT_W)
) u_bps_checker (.*);

// File: tb/byte_pair_shifter_bench.sv
module byte_pair_shifter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int MAG_W      = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       op_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic             acc_sign_i = 1'b0;
    logic [MAG_W-1:0] acc_mag_i = '0;
    logic             ext_sign_i = 1'b0;
    logic [MAG_W-1:0] ext_mag_i = '0;
    logic             ovf_i = 1'b0;
    logic             done_o, unsupported_o, acc_sign_o, ext_sign_o, ovf_o;
    logic [MAG_W-1:0] acc_mag_o, ext_mag_o;

    byte_pair_shifter u_byte_pair_shifter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .count_i(count_i),
        .acc_sign_i(acc_sign_i), .acc_mag_i(acc_mag_i), .ext_sign_i(ext_sign_i),
        .ext_mag_i(ext_mag_i), .ovf_i(ovf_i), .done_o(done_o), .unsupported_o(unsupported_o),
        .acc_sign_o(acc_sign_o), .acc_mag_o(acc_mag_o), .ext_sign_o(ext_sign_o),
        .ext_mag_o(ext_mag_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int               due;
        int               op;
        int               cnt;
        logic             as, xs, ov, unsup;
        logic [MAG_W-1:0] am, xm;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    logic [MAG_W-1:0] last_am = '0, last_xm = '0;
    logic last_as = 1'b0, last_xs = 1'b0, last_ov = 1'b0;

    function automatic logic [MAG_W-1:0] mk(int b1, int b2, int b3, int b4, int b5);
        return {6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
    endfunction

    function automatic exp_t model(int op, int cnt, logic as, logic [MAG_W-1:0] am,
                                   logic xs, logic [MAG_W-1:0] xm, logic ov);
        exp_t e;
        int p[10];
        int r[10];
        for (int i = 0; i < 5; i++) begin
            p[i]   = int'((am >> ((4 - i) * 6)) & 30'h3f);
            p[i+5] = int'((xm >> ((4 - i) * 6)) & 30'h3f);
        end
        for (int i = 0; i < 10; i++) r[i] = p[i];
        case (op)
            0: for (int i = 0; i < 5; i++) r[i] = (i + cnt < 5) ? p[i + cnt] : 0;
            1: for (int i = 0; i < 5; i++) r[i] = (i - cnt >= 0) ? p[i - cnt] : 0;
            2: for (int i = 0; i < 10; i++) r[i] = (i + cnt < 10) ? p[i + cnt] : 0;
            3: for (int i = 0; i < 10; i++) r[i] = (i - cnt >= 0) ? p[i - cnt] : 0;
            4: for (int i = 0; i < 10; i++) r[i] = p[(i + cnt % 10) % 10];
            5: for (int i = 0; i < 10; i++) r[i] = p[(i + 10 - cnt % 10) % 10];
            default: ;
        endcase
        e.am = mk(r[0], r[1], r[2], r[3], r[4]);
        e.xm = mk(r[5], r[6], r[7], r[8], r[9]);
        e.op = op; e.cnt = cnt; e.as = as; e.xs = xs; e.ov = ov;
        e.unsup = (op >= 6);
        e.due = 0;
        return e;
    endfunction

    function automatic string tag(int op, int cnt);
        if (op >= 6) return "R12";
        if (cnt == 0) return "R11";
        if (op <= 1 && cnt >= 5) return "R9";
        if ((op == 2 || op == 3) && cnt >= 10) return "R9";
        if (op >= 4 && cnt >= 10) return "R10";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, cyc, act, expv);
        end
    endtask

    // model capture at each sampling edge
    always @(posedge clk) begin
        if (rst_n && start_i) begin
            exp_t e;
            e = model(int'(op_i), int'(count_i), acc_sign_i, acc_mag_i, ext_sign_i, ext_mag_i, ovf_i);
            e.due = cyc + 2;
            q.push_back(e);
        end
        cyc <= cyc + 1;
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tag(e.op, e.cnt);
                chk(done_o === 1'b1, "R13", "done", 64'(done_o), 64'd1);
                chk(acc_mag_o === e.am, t, "acc magnitude", 64'(acc_mag_o), 64'(e.am));
                chk(ext_mag_o === e.xm, t, "ext magnitude", 64'(ext_mag_o), 64'(e.xm));
                chk(acc_sign_o === e.as && ext_sign_o === e.xs, "R7", "signs",
                    64'({acc_sign_o, ext_sign_o}), 64'({e.as, e.xs}));
                chk(ovf_o === e.ov, "R8", "overflow", 64'(ovf_o), 64'(e.ov));
                chk(unsupported_o === e.unsup, "R12", "unsupported", 64'(unsupported_o), 64'(e.unsup));
                last_am = acc_mag_o; last_xm = ext_mag_o;
                last_as = acc_sign_o; last_xs = ext_sign_o; last_ov = ovf_o;
            end else begin
                chk(done_o === 1'b0 && unsupported_o === 1'b0, "R13", "idle strobes",
                    64'({done_o, unsupported_o}), 64'd0);
                chk(acc_mag_o === last_am && ext_mag_o === last_xm && acc_sign_o === last_as
                    && ext_sign_o === last_xs && ovf_o === last_ov, "R13", "idle hold",
                    64'(acc_mag_o), 64'(last_am));
            end
        end
    end

    task automatic issue(int op, int cnt, logic as, logic [MAG_W-1:0] am,
                         logic xs, logic [MAG_W-1:0] xm, logic ov);
        @(negedge clk);
        start_i    = 1'b1;
        op_i       = 3'(op);
        count_i    = CNT_W'(cnt);
        acc_sign_i = as;
        acc_mag_i  = am;
        ext_sign_i = xs;
        ext_mag_i  = xm;
        ovf_i      = ov;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            op_i    = 3'($urandom_range(0, 7));
            count_i = CNT_W'($urandom_range(0, 20));
        end
    endtask

    initial begin
        logic [MAG_W-1:0] a, x;
        a = mk(1, 2, 3, 4, 5);
        x = mk(6, 7, 8, 9, 10);
        // reset state, R14
        repeat (3) @(negedge clk);
        chk(done_o === 1'b0 && unsupported_o === 1'b0, "R14", "reset strobes",
            64'({done_o, unsupported_o}), 64'd0);
        chk(acc_mag_o === '0 && ext_mag_o === '0, "R14", "reset magnitudes",
            64'({acc_mag_o, ext_mag_o}), 64'd0);
        chk({acc_sign_o, ext_sign_o, ovf_o} === 3'b000, "R14", "reset flags",
            64'({acc_sign_o, ext_sign_o, ovf_o}), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // directed cases, several back to back
        issue(0, 2, 1, a, 0, x, 1);        // R1
        issue(1, 1, 0, a, 1, x, 0);        // R2
        issue(2, 3, 1, a, 1, x, 0);        // R3
        issue(3, 4, 0, a, 0, x, 1);        // R4
        issue(4, 1, 1, a, 0, x, 0);        // R5
        issue(5, 2, 0, a, 1, x, 1);        // R6
        idle(3);
        issue(0, 5, 0, a, 0, x, 0);        // R9
        issue(1, 4095, 1, a, 1, x, 1);     // R9
        issue(2, 10, 0, a, 0, x, 0);       // R9
        issue(3, 11, 1, a, 0, x, 1);       // R9
        issue(2, 9, 0, a, 0, x, 0);        // R3 last byte survives
        issue(3, 9, 0, a, 0, x, 0);        // R4
        issue(4, 10, 0, a, 0, x, 0);       // R10
        issue(5, 13, 1, a, 1, x, 0);       // R10
        issue(4, 4095, 0, a, 1, x, 1);     // R10
        issue(0, 0, 1, a, 1, x, 1);        // R11
        issue(5, 0, 0, a, 0, x, 0);        // R11
        issue(6, 3, 1, a, 0, x, 1);        // R12
        issue(7, 2, 0, a, 1, x, 0);        // R12
        idle(4);

        // random patterns with mixed gaps
        for (int n = 0; n < 600; n++) begin
            int c;
            c = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 4095) : $urandom_range(0, 13);
            issue($urandom_range(0, 7), c, 1'($urandom), 30'($urandom),
                  1'($urandom), 30'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(6);
        if (q.size() != 0) chk(1'b0, "R13", "results left over", 64'(q.size()), 64'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R13 watchdog expired: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule